// File: doc/BRIEF.md
# Multi-Drive Head Seek and Recalibrate Stepper

This block positions the heads of up to four disk drives on their own. A command names one drive and asks either for a seek to a new cylinder or for a recalibrate back to cylinder zero. Each drive has its own state machine, its own present-cylinder register, its own step and direction outputs and its own busy bit. Because of this, a drive that is still stepping does not hold up commands to the other drives. A shared millisecond timebase comes from the block clock and sets the gap between step pulses. That gap comes from a 4-bit rate code and doubles when the slow-clock input is high.

When a drive finishes, the block queues a completion status byte for that drive and raises the interrupt request. A sense query takes one queued completion each time it is issued, lowest drive number first. It returns the status byte and the drive's present cylinder. A recalibrate that never sees the drive's track-zero input within a fixed number of pulses ends with an equipment-check status. While any drive is busy, a permission output tells the surrounding controller to hold off read and write commands.

Top module: `seek_stepper`

## Requirements
- R1: With slow-clock low, consecutive step pulses on a drive are (16 - rate_code) × CLK_PER_MS clock cycles apart, so rate code 4'hF gives 1 ms and 4'h0 gives 16 ms.
- R2: With slow-clock high when the command starts, the gap between step pulses is twice the R1 value.
- R3: A drive's direction output is 1 (inward) when the new cylinder is above the present cylinder and 0 (outward) for a lower cylinder or a recalibrate, and it does not change while that drive is busy.
- R4: A seek issues exactly |new - present| step pulses and leaves the present cylinder equal to the new cylinder; a seek to the present cylinder issues no pulse and still completes.
- R5: A recalibrate steps outward, checks track-zero one step interval after each pulse (and before the first), stops as soon as track-zero is seen and sets the present cylinder to 0.
- R6: A recalibrate that has issued RECAL_LIMIT (77) pulses without seeing track-zero ends with status byte 0x70 | unit (bits 7:6 = 01 abnormal, bit 5 seek end, bit 4 equipment check, bits 1:0 unit).
- R7: A successful seek or recalibrate queues status byte 0x20 | unit (seek end, bit 5), and irq stays high while any completion is queued.
- R8: Each drive has its own busy bit, set from the accepting command until completion; drives step in parallel; a command to a busy drive is ignored; rw_ok is low while any busy bit is set.
- R9: A sense query pulse is answered one cycle later on sense_valid with the status byte and present cylinder of the lowest-numbered drive with a queued completion, which it removes; with nothing queued it returns status 0x80 and cylinder 0.
- R10: low_cur for a drive is high exactly when its present cylinder is LOWCUR_CYL (42) or higher.
- R11: After reset all drives are at cylinder 0 and idle, no step pulse is driven, irq is low and rw_ok is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_clk | input | 1 | High when the controller clock runs at half rate; doubles step timing |
| rate_code | input | 4 | Step-rate code, inverted: 4'hF = 1 ms, 4'h0 = 16 ms |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_recal | input | 1 | 1 = recalibrate, 0 = seek |
| cmd_unit | input | 2 | Target drive number |
| cmd_ncn | input | 8 | New cylinder for a seek |
| track0 | input | 4 | Per-drive track-zero sense |
| sense_req | input | 1 | One-cycle interrupt-status query |
| step | output | 4 | Per-drive step pulse, one cycle wide |
| dir | output | 4 | Per-drive direction, 1 = inward |
| low_cur | output | 4 | Per-drive low write-current indicator |
| busy | output | 4 | Per-drive positioning-in-progress flag |
| rw_ok | output | 1 | High when no drive is busy |
| irq | output | 1 | Interrupt request, completions queued |
| sense_valid | output | 1 | Query answer valid |
| sense_st0 | output | 8 | Status byte of the reported drive |
| sense_pcn | output | 8 | Present cylinder of the reported drive |

## Verification
The bench sets CLK_PER_MS to 5, so a millisecond is five clock cycles. This puts the slowest 16 ms rate, the doubled slow-clock gap and a full 77-pulse failing recalibrate well within the run. RECAL_LIMIT and LOWCUR_CYL keep their default values of 77 and 42. That lets the bench check the real equipment-check count and the cylinder 41/42 boundary exactly. A drive model in the bench moves its head on every observed pulse and drives track-zero from that position. It can also hold track-zero low to force the failing case.

// File: rtl/seek_pkg.sv
package seek_pkg;
  typedef enum logic [1:0] {AX_IDLE, AX_WAIT, AX_STEP, AX_FIN} axis_state_e;

  // inverted rate code to milliseconds between pulses
  function automatic logic [4:0] step_ms(input logic [3:0] code);
    return 5'd16 - {1'b0, code};
  endfunction

  function automatic logic [7:0] next_cyl(input logic [7:0] cyl, input logic inward);
    return inward ? cyl + 8'd1 : cyl - 8'd1;
  endfunction

  // completion status: [7:6] code, [5] seek end, [4] equipment check, [1:0] unit
  function automatic logic [7:0] make_st0(input logic failed, input logic [1:0] unit);
    return {failed ? 2'b01 : 2'b00, 1'b1, failed, 2'b00, unit};
  endfunction

  localparam logic [7:0] ST0_EMPTY = 8'h80;
endpackage

// File: rtl/ms_timebase.sv
module ms_timebase #(
  parameter int CLK_PER_MS = 8000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slow,
  output logic tick
);
  localparam int CNT_W = $clog2(2 * CLK_PER_MS + 1);
  localparam logic [CNT_W-1:0] FAST_END = CNT_W'(CLK_PER_MS - 1);
  localparam logic [CNT_W-1:0] SLOW_END = CNT_W'(2 * CLK_PER_MS - 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;
  logic wrap;

  assign lim  = slow ? SLOW_END : FAST_END;
  assign wrap = (cnt >= lim);
  assign tick = wrap;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= wrap ? '0 : cnt + 1'b1;
  end

  // one tick per period; never on consecutive cycles
  assert_tick_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/drive_axis.sv
module drive_axis
  import seek_pkg::*;
#(
  parameter int CYL_W       = 8,
  parameter int RECAL_LIMIT = 77
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [4:0]       interval,
  input  logic             start,
  input  logic             recal,
  input  logic [CYL_W-1:0] ncn,
  input  logic             track0,
  output logic             step,
  output logic             dir,
  output logic             busy,
  output logic             done,
  output logic             fail,
  output logic [CYL_W-1:0] pcn
);
  localparam int STEP_W = $clog2(RECAL_LIMIT + 1);

  axis_state_e      st;
  logic [4:0]       ms_left;
  logic [4:0]       ivl;
  logic [CYL_W-1:0] tgt;
  logic             is_recal;
  logic [STEP_W-1:0] nsteps;
  logic [CYL_W-1:0] cyl_next;
  logic             expire;

  assign cyl_next = CYL_W'(next_cyl(8'(pcn), dir));
  assign expire   = (st == AX_WAIT) && tick && (ms_left == 5'd1);
  assign step     = (st == AX_STEP);
  assign busy     = (st != AX_IDLE);
  assign done     = (st == AX_FIN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= AX_IDLE;
      ms_left  <= '0;
      ivl      <= '0;
      tgt      <= '0;
      is_recal <= 1'b0;
      nsteps   <= '0;
      dir      <= 1'b0;
      fail     <= 1'b0;
      pcn      <= '0;
    end else begin
      unique case (st)
        AX_IDLE: if (start) begin
          is_recal <= recal;
          tgt      <= ncn;
          ivl      <= interval;
          ms_left  <= interval;
          nsteps   <= '0;
          fail     <= 1'b0;
          dir      <= recal ? 1'b0 : (ncn > pcn);
          st       <= (!recal && ncn == pcn) ? AX_FIN : AX_WAIT;
        end
        AX_WAIT: if (expire) begin
          if (is_recal && track0) begin
            pcn <= '0;
            st  <= AX_FIN;
          end else if (is_recal && nsteps == STEP_W'(RECAL_LIMIT)) begin
            fail <= 1'b1;
            st   <= AX_FIN;
          end else begin
            st <= AX_STEP;
          end
        end else if (tick) begin
          ms_left <= ms_left - 5'd1;
        end
        AX_STEP: begin
          ms_left <= ivl;
          if (is_recal) begin
            nsteps <= nsteps + 1'b1;
            st     <= AX_WAIT;
          end else begin
            pcn <= cyl_next;
            st  <= (cyl_next == tgt) ? AX_FIN : AX_WAIT;
          end
        end
        AX_FIN: st <= AX_IDLE;
        default: st <= AX_IDLE;
      endcase
    end
  end

  assert_dir_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(dir));
  assert_seek_moves_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !is_recal) |=> (pcn != $past(pcn)));
  assert_recal_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    nsteps <= STEP_W'(RECAL_LIMIT));
  assert_step_while_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> busy);
endmodule

// File: rtl/irq_queue.sv
module irq_queue
  import seek_pkg::*;
#(
  parameter int NUM_DRIVES = 4,
  parameter int CYL_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NUM_DRIVES-1:0] done,
  input  logic [NUM_DRIVES-1:0] fail,
  input  logic [CYL_W-1:0] pcn [NUM_DRIVES],
  input  logic             sense_req,
  output logic             irq,
  output logic             sense_valid,
  output logic [7:0]       sense_st0,
  output logic [7:0]       sense_pcn
);
  localparam int UNIT_W = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1;

  logic [NUM_DRIVES-1:0] pend;
  logic [7:0]            st0_q [NUM_DRIVES];
  logic [UNIT_W-1:0]     pick;
  logic                  pick_hit;

  always_comb begin
    pick_hit = 1'b0;
    pick     = '0;
    for (int i = NUM_DRIVES - 1; i >= 0; i--) begin
      if (pend[i]) begin
        pick_hit = 1'b1;
        pick     = UNIT_W'(i);
      end
    end
  end

  assign irq = |pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend        <= '0;
      sense_valid <= 1'b0;
      sense_st0   <= '0;
      sense_pcn   <= '0;
      for (int i = 0; i < NUM_DRIVES; i++) st0_q[i] <= '0;
    end else begin
      sense_valid <= sense_req;
      if (sense_req) begin
        if (pick_hit) begin
          sense_st0  <= st0_q[pick];
          sense_pcn  <= 8'(pcn[pick]);
          pend[pick] <= 1'b0;
        end else begin
          sense_st0 <= ST0_EMPTY;
          sense_pcn <= '0;
        end
      end
      for (int i = 0; i < NUM_DRIVES; i++) begin
        if (done[i]) begin
          pend[i]  <= 1'b1;
          st0_q[i] <= make_st0(fail[i], 2'(i));
        end
      end
    end
  end

  assert_answer_follows_query_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sense_valid |-> $past(sense_req));
  assert_irq_after_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|done) |=> irq);
endmodule

// File: rtl/seek_stepper.sv
module seek_stepper
  import seek_pkg::*;
#(
  parameter int CLK_PER_MS  = 8000,
  parameter int NUM_DRIVES  = 4,
  parameter int CYL_W       = 8,
  parameter int RECAL_LIMIT = 77,
  parameter int LOWCUR_CYL  = 42
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  slow_clk,
  input  logic [3:0]            rate_code,
  input  logic                  cmd_valid,
  input  logic                  cmd_recal,
  input  logic [1:0]            cmd_unit,
  input  logic [7:0]            cmd_ncn,
  input  logic [NUM_DRIVES-1:0] track0,
  input  logic                  sense_req,
  output logic [NUM_DRIVES-1:0] step,
  output logic [NUM_DRIVES-1:0] dir,
  output logic [NUM_DRIVES-1:0] low_cur,
  output logic [NUM_DRIVES-1:0] busy,
  output logic                  rw_ok,
  output logic                  irq,
  output logic                  sense_valid,
  output logic [7:0]            sense_st0,
  output logic [7:0]            sense_pcn
);
  logic                  tick;
  logic [4:0]            interval;
  logic [NUM_DRIVES-1:0] done;
  logic [NUM_DRIVES-1:0] fail;
  logic [NUM_DRIVES-1:0] start;
  logic [CYL_W-1:0]      pcn [NUM_DRIVES];

  assign interval = step_ms(rate_code);
  assign rw_ok    = ~|busy;

  ms_timebase #(.CLK_PER_MS(CLK_PER_MS)) u_tb (
    .clk(clk), .rst_n(rst_n), .slow(slow_clk), .tick(tick));

  for (genvar g = 0; g < NUM_DRIVES; g++) begin : g_drv
    assign start[g]   = cmd_valid && (cmd_unit == 2'(g)) && !busy[g];
    assign low_cur[g] = (pcn[g] >= CYL_W'(LOWCUR_CYL));

    drive_axis #(.CYL_W(CYL_W), .RECAL_LIMIT(RECAL_LIMIT)) u_ax (
      .clk(clk), .rst_n(rst_n), .tick(tick), .interval(interval),
      .start(start[g]), .recal(cmd_recal), .ncn(CYL_W'(cmd_ncn)),
      .track0(track0[g]), .step(step[g]), .dir(dir[g]), .busy(busy[g]),
      .done(done[g]), .fail(fail[g]), .pcn(pcn[g]));

    assert_busy_ignores_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy[g] && !done[g]) |=> busy[g]);
  end

  irq_queue #(.NUM_DRIVES(NUM_DRIVES), .CYL_W(CYL_W)) u_q (
    .clk(clk), .rst_n(rst_n), .done(done), .fail(fail), .pcn(pcn),
    .sense_req(sense_req), .irq(irq), .sense_valid(sense_valid),
    .sense_st0(sense_st0), .sense_pcn(sense_pcn));

  assert_no_rw_while_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy[0]) |-> !rw_ok);
endmodule

// File: tb/tb_seek_stepper.sv
module tb_seek_stepper;
  localparam int CPM = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slow_clk = 1'b0;
  logic [3:0] rate_code = 4'hF;
  logic cmd_valid = 1'b0;
  logic cmd_recal = 1'b0;
  logic [1:0] cmd_unit = 2'd0;
  logic [7:0] cmd_ncn = 8'd0;
  logic [3:0] track0;
  logic sense_req = 1'b0;
  logic [3:0] step, dir, low_cur, busy;
  logic rw_ok, irq, sense_valid;
  logic [7:0] sense_st0, sense_pcn;

  always #5 clk = ~clk;

  seek_stepper #(.CLK_PER_MS(CPM)) dut (
    .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk), .rate_code(rate_code),
    .cmd_valid(cmd_valid), .cmd_recal(cmd_recal), .cmd_unit(cmd_unit),
    .cmd_ncn(cmd_ncn), .track0(track0), .sense_req(sense_req),
    .step(step), .dir(dir), .low_cur(low_cur), .busy(busy), .rw_ok(rw_ok),
    .irq(irq), .sense_valid(sense_valid), .sense_st0(sense_st0), .sense_pcn(sense_pcn));

  int checks = 0;
  int errors = 0;
  longint cyc = 0;
  int pos [4];
  int cnt [4];
  longint last [4];
  longint gap0 [4];
  bit gap_bad [4];
  bit last_dir [4];
  bit stuck [4];

  typedef struct packed {
    logic [1:0] u; logic rc; logic [7:0] ncn; logic [3:0] rate; logic slow;
    logic [7:0] steps; logic dr; logic [7:0] pcn; logic [7:0] st0;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{2'd0, 1'b0, 8'd5,  4'hF, 1'b0, 8'd5,  1'b1, 8'd5,  8'h20},
    '{2'd0, 1'b0, 8'd2,  4'hE, 1'b1, 8'd3,  1'b0, 8'd2,  8'h20},
    '{2'd1, 1'b0, 8'd45, 4'hF, 1'b0, 8'd45, 1'b1, 8'd45, 8'h21},
    '{2'd1, 1'b1, 8'd0,  4'hF, 1'b0, 8'd45, 1'b0, 8'd0,  8'h21},
    '{2'd2, 1'b0, 8'd0,  4'h3, 1'b0, 8'd0,  1'b0, 8'd0,  8'h22},
    '{2'd3, 1'b0, 8'd3,  4'h0, 1'b0, 8'd3,  1'b1, 8'd3,  8'h23}
  };

  always @(posedge clk) cyc <= cyc + 1;

  always_comb begin
    for (int i = 0; i < 4; i++) track0[i] = (pos[i] == 0) && !stuck[i];
  end

  // drive model: follow every pulse, record spacing and direction
  always @(negedge clk) begin
    for (int i = 0; i < 4; i++) begin
      if (rst_n && step[i]) begin
        cnt[i] = cnt[i] + 1;
        if (dir[i]) pos[i] = pos[i] + 1;
        else if (pos[i] != 0) pos[i] = pos[i] - 1;
        if (cnt[i] == 2) gap0[i] = cyc - last[i];
        else if (cnt[i] > 2 && (cyc - last[i]) != gap0[i]) gap_bad[i] = 1'b1;
        last[i] = cyc;
        last_dir[i] = dir[i];
      end
    end
  end

  task automatic check(input string req, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
    end
  endtask

  task automatic summary;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic clr(input int u);
    cnt[u] = 0; gap0[u] = 0; gap_bad[u] = 1'b0;
  endtask

  task automatic issue(input int u, input bit rc, input int ncn);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_recal = rc; cmd_unit = 2'(u); cmd_ncn = 8'(ncn);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle(input int u);
    for (int k = 0; k < 20000 && busy[u]; k++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic sense(output logic v, output logic [7:0] s0, output logic [7:0] pc);
    @(negedge clk);
    sense_req = 1'b1;
    @(negedge clk);
    sense_req = 1'b0;
    v = sense_valid; s0 = sense_st0; pc = sense_pcn;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    logic v;
    logic [7:0] s0, pc;
    for (int i = 0; i < 4; i++) begin pos[i] = 0; stuck[i] = 1'b0; last[i] = 0; clr(i); end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check("R11 busy", busy, 0);
    check("R11 step", step, 0);
    check("R11 irq", irq, 0);
    check("R11 rw_ok", rw_ok, 1);
    // R9 empty query
    sense(v, s0, pc);
    check("R9 empty valid", v, 1);
    check("R9 empty st0", s0, 8'h80);
    check("R9 empty pcn", pc, 0);

    foreach (VEC[n]) begin
      vec_t e;
      int u;
      e = VEC[n];
      u = int'(e.u);
      rate_code = e.rate;
      slow_clk = e.slow;
      clr(u);
      issue(u, e.rc, int'(e.ncn));
      wait_idle(u);
      check(e.rc ? "R5 recal pulses" : "R4 seek pulses", cnt[u], e.steps);
      if (e.steps != 0) check("R3 direction", last_dir[u], e.dr);
      if (e.steps >= 2) begin
        check(e.slow ? "R2 doubled gap" : "R1 step gap", gap0[u],
              (16 - int'(e.rate)) * CPM * (e.slow ? 2 : 1));
        check("R1 even spacing", gap_bad[u], 0);
      end
      check("R7 irq queued", irq, 1);
      sense(v, s0, pc);
      check("R7 status byte", s0, e.st0);
      check(e.rc ? "R5 cylinder zero" : "R4 final cylinder", pc, e.pcn);
      check("R10 low current", low_cur[u], (e.pcn >= 42) ? 1 : 0);
      check("R9 irq cleared", irq, 0);
    end
    slow_clk = 1'b0;
    rate_code = 4'hF;

    // R6 track-zero never seen
    stuck[2] = 1'b1;
    pos[2] = 5;
    clr(2);
    issue(2, 1'b1, 0);
    wait_idle(2);
    check("R6 pulse limit", cnt[2], 77);
    sense(v, s0, pc);
    check("R6 fail status", s0, 8'h72);
    stuck[2] = 1'b0;

    // R10 boundary 41 / 42
    issue(0, 1'b0, 41);
    wait_idle(0);
    check("R10 at 41", low_cur[0], 0);
    sense(v, s0, pc);
    issue(0, 1'b0, 42);
    wait_idle(0);
    check("R10 at 42", low_cur[0], 1);
    sense(v, s0, pc);

    // R8 parallel drives, busy drive ignores a command, R9 drive order
    issue(0, 1'b0, 10);
    issue(3, 1'b0, 4);
    check("R8 both busy", {busy[3], busy[0]}, 2'b11);
    check("R8 rw refused", rw_ok, 0);
    issue(0, 1'b0, 99);
    wait_idle(3);
    check("R8 drive0 still busy", busy[0], 1);
    wait_idle(0);
    check("R8 rw allowed", rw_ok, 1);
    sense(v, s0, pc);
    check("R9 first is drive0", s0, 8'h20);
    check("R8 ignored command", pc, 10);
    sense(v, s0, pc);
    check("R9 second is drive3", s0, 8'h23);
    check("R9 drive3 cylinder", pc, 4);
    sense(v, s0, pc);
    check("R9 queue drained", s0, 8'h80);
    summary();
  end
endmodule